// File: doc/BRIEF.md
# Multi-CPU Doorbell Interrupt Unit

This block holds a per-CPU bank of doorbell bits that other agents ring by writing one shared trigger word. A trigger word names a doorbell index in its low five bits and a set of target CPUs in a bitmap starting at bit 8. Every CPU it names gets that doorbell bit set in its own cause register. Doorbells 0 to 7 serve inter-processor signalling. Doorbells 16 to 31 serve message-signalled interrupts, which reach the block as plain trigger writes on a dedicated inbound port.

Each CPU owns a cause register and a mask register. Software acknowledges doorbells by writing the cause register. A zero in the written word clears the bit in that position, and a one leaves it as it is. Writing the complement of the handled set therefore acknowledges exactly that set. Each CPU drives two level outputs toward its interrupt controller: one for pending unmasked inter-processor doorbells and one for pending unmasked message doorbells. A register read port returns cause and mask contents.

Top module: `doorbell_unit`

## Requirements
- R1: After reset every cause and mask register reads 0, and every ipi_irq and msi_irq output is low.
- R2: A host write to address 0x004 is a trigger. Data bits [4:0] give the doorbell index, and data bit 8+c selects CPU c. The indexed bit becomes set in the cause register of every selected CPU after the clock edge that takes the write.
- R3: A trigger whose index is 8 to 15 sets no bit. Map bits for CPU numbers at or above NUM_CPU are ignored.
- R4: An inbound message (msi_valid high with msi_data) is decoded exactly like a trigger write. The data value 0xF00 | (n+16) sets cause bit n+16 in CPUs 0 to 3.
- R5: A host write to the cause register of CPU c (address 0x100 + 16c + 0x8) clears each bit written as 0 and keeps each bit written as 1. Other CPUs' cause registers are unaffected.
- R6: A host write to the mask register of CPU c (address 0x100 + 16c + 0xC) stores bits [7:0] and [31:16]. Bits [15:8] of mask and cause always read 0.
- R7: ipi_irq[c] is high exactly when some bit in [7:0] is set in both cause and mask of CPU c.
- R8: msi_irq[c] is high exactly when some bit in [31:16] is set in both cause and mask of CPU c.
- R9: When a trigger and a cause write that clears the same bit land in the same cycle, the bit ends up set.
- R10: A host trigger and an inbound message in the same cycle both take effect.
- R11: rd_data reflects the register at rd_addr in the same cycle. Any address that is neither a cause nor a mask register reads 0, including the trigger address.
- R12: A masked doorbell is still recorded in cause, and a later unmask raises the summary output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | ADDR_W | Host write byte address |
| wr_data | input | 32 | Host write data |
| msi_valid | input | 1 | Inbound message trigger strobe |
| msi_data | input | 32 | Inbound message data, trigger format |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data (combinational) |
| ipi_irq | output | NUM_CPU | Per-CPU pending unmasked doorbell in [7:0] |
| msi_irq | output | NUM_CPU | Per-CPU pending unmasked doorbell in [31:16] |

## Verification
Two functions can hit the same cause bit in one cycle: a trigger from either port sets it while a software acknowledge clears it. The bench provokes this by pairing an inbound message with a host cause write whose data has a zero at that message's bit. It expects the bit to survive, and it checks the other acknowledged bits to confirm they cleared. It also drives a host trigger and an inbound message together and expects both bits set.

// File: rtl/db_pkg.sv
package db_pkg;
   localparam int DB_W  = 32;
   localparam int IDX_W = 5;

   // mask with n ones starting at lsb
   function automatic logic [DB_W-1:0] span_mask(input int lsb, input int n);
      logic [DB_W-1:0] m;
      m = '0;
      for (int i = 0; i < DB_W; i++)
         if (i >= lsb && i < lsb + n) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/db_trig_dec.sv
module db_trig_dec
   import db_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int MAP_LSB = 8,
   parameter logic [DB_W-1:0] IMPL = 32'hFFFF_00FF
) (
   input  logic                           valid,
   input  logic [DB_W-1:0]                data,
   output logic [NUM_CPU-1:0][DB_W-1:0]   set_vec
);
   initial begin
      if (MAP_LSB < IDX_W || MAP_LSB + NUM_CPU > DB_W)
         $error("db_trig_dec: cpu map field does not fit");
   end

   logic [DB_W-1:0] bit_sel;

   always_comb begin
      bit_sel = IMPL & (DB_W'(1) << data[IDX_W-1:0]);
   end

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      always_comb begin
         set_vec[c] = (valid && data[MAP_LSB + c]) ? bit_sel : '0;
      end
   end
endmodule

// File: rtl/db_cpu_regs.sv
module db_cpu_regs
   import db_pkg::*;
#(
   parameter logic [DB_W-1:0] IMPL    = 32'hFFFF_00FF,
   parameter logic [DB_W-1:0] IPI_SEL = 32'h0000_00FF,
   parameter logic [DB_W-1:0] MSI_SEL = 32'hFFFF_0000,
   parameter bit              IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DB_W-1:0] set_bits,
   input  logic            clr_we,
   input  logic [DB_W-1:0] clr_data,
   input  logic            mask_we,
   input  logic [DB_W-1:0] mask_data,
   output logic [DB_W-1:0] cause,
   output logic [DB_W-1:0] mask,
   output logic            ipi_irq,
   output logic            msi_irq
);
   logic [DB_W-1:0] cause_nxt;
   logic            ipi_any, msi_any;

   always_comb begin
      cause_nxt = cause;
      if (clr_we) cause_nxt = cause_nxt & clr_data;
      cause_nxt = (cause_nxt | set_bits) & IMPL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause <= '0;
         mask  <= '0;
      end else begin
         cause <= cause_nxt;
         if (mask_we) mask <= mask_data & IMPL;
      end
   end

   always_comb begin
      ipi_any = |(cause & mask & IPI_SEL);
      msi_any = |(cause & mask & MSI_SEL);
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ipi_irq <= 1'b0;
            msi_irq <= 1'b0;
         end else begin
            ipi_irq <= ipi_any;
            msi_irq <= msi_any;
         end
      end
   end else begin : g_irq_comb
      always_comb begin
         ipi_irq = ipi_any;
         msi_irq = msi_any;
      end
   end

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits != '0) |=> ((cause & $past(set_bits)) == $past(set_bits)));
   // R5
   no_spurious_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits == '0) |=> ((cause & ~$past(cause)) == '0));
   // R5
   cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && set_bits == '0) |=> $stable(cause));
   // R6
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask));
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
   import db_pkg::*;
#(
   parameter int NUM_CPU    = 4,
   parameter int ADDR_W     = 12,
   parameter int TRIG_OFS   = 'h004,
   parameter int CPU_BASE   = 'h100,
   parameter int CPU_STRIDE = 'h10,
   parameter int CAUSE_OFS  = 'h8,
   parameter int MASK_OFS   = 'hC,
   parameter int MAP_LSB    = 8,
   parameter int IPI_LSB    = 0,
   parameter int IPI_BITS   = 8,
   parameter int MSI_LSB    = 16,
   parameter int MSI_BITS   = 16,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [31:0]         wr_data,
   input  logic                msi_valid,
   input  logic [31:0]         msi_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [31:0]         rd_data,
   output logic [NUM_CPU-1:0]  ipi_irq,
   output logic [NUM_CPU-1:0]  msi_irq
);
   localparam logic [DB_W-1:0] IPI_SEL = span_mask(IPI_LSB, IPI_BITS);
   localparam logic [DB_W-1:0] MSI_SEL = span_mask(MSI_LSB, MSI_BITS);
   localparam logic [DB_W-1:0] IMPL    = IPI_SEL | MSI_SEL;
   localparam int              TOP_ADR = CPU_BASE + NUM_CPU * CPU_STRIDE;

   initial begin
      if (NUM_CPU < 1 || NUM_CPU > 8) $error("doorbell_unit: NUM_CPU out of range");
      if (IPI_LSB + IPI_BITS > MSI_LSB) $error("doorbell_unit: doorbell groups overlap");
      if (MSI_LSB + MSI_BITS > DB_W) $error("doorbell_unit: message group too wide");
      if (TOP_ADR > (1 << ADDR_W)) $error("doorbell_unit: address space too small");
      if (CAUSE_OFS >= CPU_STRIDE || MASK_OFS >= CPU_STRIDE || CAUSE_OFS == MASK_OFS)
         $error("doorbell_unit: bad per-cpu register layout");
   end

   logic                         host_trig;
   logic [NUM_CPU-1:0][DB_W-1:0] host_set, msi_set;
   logic [NUM_CPU-1:0][DB_W-1:0] cause_q, mask_q;

   assign host_trig = wr_en && (wr_addr == ADDR_W'(TRIG_OFS));

   db_trig_dec #(.NUM_CPU(NUM_CPU), .MAP_LSB(MAP_LSB), .IMPL(IMPL)) u_host_dec (
      .valid(host_trig), .data(wr_data), .set_vec(host_set));

   db_trig_dec #(.NUM_CPU(NUM_CPU), .MAP_LSB(MAP_LSB), .IMPL(IMPL)) u_msi_dec (
      .valid(msi_valid), .data(msi_data), .set_vec(msi_set));

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      localparam logic [ADDR_W-1:0] CAUSE_A = ADDR_W'(CPU_BASE + c * CPU_STRIDE + CAUSE_OFS);
      localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(CPU_BASE + c * CPU_STRIDE + MASK_OFS);
      logic clr_we, mask_we;

      assign clr_we  = wr_en && (wr_addr == CAUSE_A);
      assign mask_we = wr_en && (wr_addr == MASK_A);

      db_cpu_regs #(.IMPL(IMPL), .IPI_SEL(IPI_SEL), .MSI_SEL(MSI_SEL), .IRQ_REG(IRQ_REG)) u_regs (
         .clk(clk), .rst_n(rst_n),
         .set_bits(host_set[c] | msi_set[c]),
         .clr_we(clr_we), .clr_data(wr_data),
         .mask_we(mask_we), .mask_data(wr_data),
         .cause(cause_q[c]), .mask(mask_q[c]),
         .ipi_irq(ipi_irq[c]), .msi_irq(msi_irq[c]));

      // R10
      both_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (host_set[c] != '0 && msi_set[c] != '0) |=>
            ((cause_q[c] & ($past(host_set[c]) | $past(msi_set[c])))
               == ($past(host_set[c]) | $past(msi_set[c]))));
   end

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CPU; c++) begin
         if (rd_addr == ADDR_W'(CPU_BASE + c * CPU_STRIDE + CAUSE_OFS)) rd_data = cause_q[c];
         if (rd_addr == ADDR_W'(CPU_BASE + c * CPU_STRIDE + MASK_OFS))  rd_data = mask_q[c];
      end
   end
endmodule

// File: tb/tb_doorbell_unit.sv
`timescale 1ns/1ps
module tb_doorbell_unit;
   localparam int NC = 4;
   localparam logic [31:0] IMPL = 32'hFFFF_00FF;
   localparam logic [11:0] TRIG = 12'h004;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        msi_valid = 1'b0;
   logic [31:0] msi_data = '0;
   logic [11:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic [NC-1:0] ipi_irq, msi_irq;

   int vectors = 0;
   int miscompares = 0;
   logic [31:0] ex_cause [NC];
   logic [31:0] ex_mask  [NC];

   always #2 clk = ~clk;

   doorbell_unit dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .msi_valid(msi_valid), .msi_data(msi_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .ipi_irq(ipi_irq), .msi_irq(msi_irq));

   function automatic logic [11:0] cause_a(input int c);
      return 12'(12'h100 + c * 16 + 8);
   endfunction
   function automatic logic [11:0] mask_a(input int c);
      return 12'(12'h100 + c * 16 + 12);
   endfunction
   // bits a trigger word sets for cpu c
   function automatic logic [31:0] trig_bits(input logic [31:0] d, input int c);
      logic [31:0] b;
      b = 32'h1 << d[4:0];
      if (!d[8 + c]) return '0;
      return b & IMPL;
   endfunction

   task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                       input logic mv, input logic [31:0] md);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; msi_valid = mv; msi_data = md;
      for (int c = 0; c < NC; c++) begin
         logic [31:0] n;
         n = ex_cause[c];
         if (we && a == cause_a(c)) n = n & d;
         if (we && a == mask_a(c)) ex_mask[c] = d & IMPL;
         if (we && a == TRIG) n = n | trig_bits(d, c);
         if (mv) n = n | trig_bits(md, c);
         ex_cause[c] = n & IMPL;
      end
      @(posedge clk);
      #1;
      wr_en = 1'b0; msi_valid = 1'b0;
   endtask

   task automatic check_all(input string rc, input string rm);
      for (int c = 0; c < NC; c++) begin
         rd_addr = cause_a(c); #1;
         cmp(rc, rd_data, ex_cause[c]);
         rd_addr = mask_a(c); #1;
         cmp(rm, rd_data, ex_mask[c]);
         cmp("R7", 32'(ipi_irq[c]), 32'(|(ex_cause[c][7:0] & ex_mask[c][7:0])));
         cmp("R8", 32'(msi_irq[c]), 32'(|(ex_cause[c][31:16] & ex_mask[c][31:16])));
      end
   endtask

   initial begin
      #800000;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      for (int c = 0; c < NC; c++) begin ex_cause[c] = '0; ex_mask[c] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      check_all("R1", "R1");

      // R6 mask write keeps only implemented bits
      for (int c = 0; c < NC; c++) step(1'b1, mask_a(c), 32'hFFFF_FFFF, 1'b0, '0);
      check_all("R6", "R6");
      // R2 trigger bit 3 to cpus 0 and 2
      step(1'b1, TRIG, 32'h0000_0503, 1'b0, '0);
      check_all("R2", "R6");
      // R3 index 12 sets nothing; map bit for cpu 4 ignored
      step(1'b1, TRIG, 32'h0000_0F0C, 1'b0, '0);
      step(1'b1, TRIG, 32'h0000_1001, 1'b0, '0);
      check_all("R3", "R6");
      // R4 message number 5 -> bit 21 in all cpus
      step(1'b0, '0, '0, 1'b1, 32'h0000_0F15);
      check_all("R4", "R6");
      // R5 acknowledge bit 21 on cpu 1 only
      step(1'b1, cause_a(1), ~32'h0020_0000, 1'b0, '0);
      check_all("R5", "R6");
      // R9 message sets bit 16 while cpu 0 clears everything
      step(1'b1, cause_a(0), 32'h0, 1'b1, 32'h0000_0F10);
      check_all("R9", "R6");
      // R10 host trigger and message together
      step(1'b1, TRIG, 32'h0000_0206, 1'b1, 32'h0000_0F1F);
      check_all("R10", "R6");
      // R12 masked doorbell recorded, raised on unmask
      step(1'b1, mask_a(3), 32'h0, 1'b0, '0);
      step(1'b1, TRIG, 32'h0000_0807, 1'b0, '0);
      check_all("R12", "R6");
      step(1'b1, mask_a(3), 32'h0000_0080, 1'b0, '0);
      check_all("R12", "R12");
      // R11 unmapped and trigger addresses read zero
      rd_addr = 12'h0F0; #1; cmp("R11", rd_data, '0);
      rd_addr = TRIG;    #1; cmp("R11", rd_data, '0);

      for (int v = 0; v < 400; v++) begin
         int k, c;
         logic [31:0] d, md;
         k = $urandom % 6;
         c = $urandom % NC;
         d = $urandom;
         md = 32'h0000_0F10 | ($urandom % 16);
         case (k)
            0: step(1'b1, TRIG, d & 32'h0000_0F1F, 1'b0, '0);
            1: step(1'b0, '0, '0, 1'b1, md);
            2: step(1'b1, cause_a(c), d | $urandom, 1'b0, '0);
            3: step(1'b1, mask_a(c), d, 1'b0, '0);
            4: step(1'b1, cause_a(c), d & $urandom, 1'b1, md);
            default: step(1'b1, 12'h0F8, d, 1'b0, '0);
         endcase
         check_all("R5", "R6");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule